// File: doc/BRIEF.md
# Domain and Access Permission Checker

This block decides, within a single combinational evaluation, whether a memory access that has already hit a translation entry may proceed. It receives the cached entry's mapping kind, its domain number and its four access-permission slots, together with the two pairs of virtual address bits that pick a subpage, the access direction, the current privilege level and the two system protection bits. It returns a two-bit fault code and the domain number to record.

The domain's mode is read from a packed domain access word that holds two bits per domain. A manager domain always lets the access through. A client domain has its permissions checked against the permission slot that the mapping kind and the address select. Any other domain mode raises a section domain fault. Address translation, table walks and the fault status and address registers are handled by neighbouring logic.

Top module: `dom_perm_checker`

## Requirements
- R1: The mode of domain d is bits [2d+1:2d] of `dom_ctrl`; mode 0 is no access, 1 is client, 2 is reserved, 3 is manager.
- R2: When the selected domain's mode is 3 (manager), `fault_code` is 0 (no fault) whatever the permissions, direction or privilege.
- R3: When the selected domain's mode is 0 or 2, `fault_code` is 3 (section domain fault) whatever the permissions.
- R4: Permission slot k is `ap_slots[2k+1:2k]`. For a small page (`map_kind` 1) the slot index is `va_small_sel` (address bits 11:10); for a large page (`map_kind` 2) it is `va_large_sel` (address bits 15:14).
- R5: A section (`map_kind` 0) uses slot 3. A tiny page (`map_kind` 3), an extended small page (`map_kind` 4) and the unused codes 5 to 7 use slot 0.
- R6: Permission value 3 allows every access; value 2 allows privileged reads and writes and user reads only; value 1 allows privileged accesses only.
- R7: Permission value 0 refuses every write; a read is allowed when `sys_r` is 1, or when the access is privileged and `sys_s` is 1.
- R8: In a client domain a refused access gives `fault_code` 1 (section permission fault) for a section and 2 (page permission fault) for every other mapping kind; an allowed access gives 0.
- R9: `fault_dom` equals `dom_id` whenever `fault_code` is not 0, and is 0 when there is no fault.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| map_kind | input | 3 | Mapping kind of the translation entry |
| dom_id | input | 4 | Domain number of the entry |
| ap_slots | input | 8 | Four 2-bit access-permission slots |
| va_small_sel | input | 2 | Virtual address bits 11:10 |
| va_large_sel | input | 2 | Virtual address bits 15:14 |
| is_write | input | 1 | 1 for a write access, 0 for a read |
| is_priv | input | 1 | 1 when the processor is privileged |
| sys_s | input | 1 | System protection bit S |
| sys_r | input | 1 | ROM protection bit R |
| dom_ctrl | input | 32 | Domain access word, 2 bits per domain |
| fault_code | output | 2 | 0 none, 1 section permission, 2 page permission, 3 section domain |
| fault_dom | output | 4 | Domain to record with a fault |

## Verification
The bench builds the checker with its default of sixteen domains, so the full 4-bit domain number and the 32-bit domain word are both exercised, including the top domain whose mode sits in the uppermost bits. With that width every combination of mapping kind, slot index, permission value, direction, privilege and system bit is reachable from random stimulus, while directed vectors pin down the slot choice per mapping kind and the read-only cases of permission value 0.

// File: rtl/dapc_pkg.sv
package dapc_pkg;

    localparam int NUM_DOMAINS = 16;
    localparam int DOM_W       = $clog2(NUM_DOMAINS);
    localparam int MODE_W      = 2;
    localparam int AP_W        = 2;
    localparam int AP_SLOTS    = 4;
    localparam int SLOT_IDX_W  = $clog2(AP_SLOTS);

    typedef enum logic [2:0] {
        MAP_SECTION = 3'd0,
        MAP_SMALL   = 3'd1,
        MAP_LARGE   = 3'd2,
        MAP_TINY    = 3'd3,
        MAP_XSMALL  = 3'd4
    } map_kind_e;

    typedef enum logic [1:0] {
        DM_NOACC   = 2'd0,
        DM_CLIENT  = 2'd1,
        DM_RSVD    = 2'd2,
        DM_MANAGER = 2'd3
    } dom_mode_e;

    typedef enum logic [1:0] {
        FLT_NONE      = 2'd0,
        FLT_SECT_PERM = 2'd1,
        FLT_PAGE_PERM = 2'd2,
        FLT_SECT_DOM  = 2'd3
    } fault_e;

    typedef struct packed {
        logic is_write;
        logic is_priv;
        logic sys_s;
        logic sys_r;
    } acc_ctx_t;

    function automatic logic ap_allows(input logic [AP_W-1:0] ap, input acc_ctx_t c);
        logic ok;
        case (ap)
            2'd3:    ok = 1'b1;
            2'd2:    ok = c.is_priv | ~c.is_write;
            2'd1:    ok = c.is_priv;
            default: ok = ~c.is_write & (c.sys_r | (c.is_priv & c.sys_s));
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/dom_mode_lookup.sv
module dom_mode_lookup
    import dapc_pkg::*;
#(
    parameter int N_DOM = NUM_DOMAINS,
    localparam int IDW  = $clog2(N_DOM)
) (
    input  logic [2*N_DOM-1:0] dom_ctrl,
    input  logic [IDW-1:0]     dom_id,
    output dom_mode_e          mode
);
    logic [MODE_W-1:0] field [N_DOM];

    for (genvar d = 0; d < N_DOM; d++) begin : g_field
        assign field[d] = dom_ctrl[2*d +: MODE_W];
    end

    assign mode = dom_mode_e'(field[dom_id]);

    always_comb begin
        p_mode_range_r1: assert (^mode !== 1'bx || ^dom_ctrl === 1'bx)
            else $error("domain mode unknown with known control word");
    end
endmodule

// File: rtl/ap_select.sv
module ap_select
    import dapc_pkg::*;
(
    input  logic [2:0]               kind,
    input  logic [AP_SLOTS*AP_W-1:0] slots,
    input  logic [SLOT_IDX_W-1:0]    small_sel,
    input  logic [SLOT_IDX_W-1:0]    large_sel,
    output logic [AP_W-1:0]          ap,
    output logic                     is_section
);
    logic [AP_W-1:0]       slot [AP_SLOTS];
    logic [SLOT_IDX_W-1:0] idx;

    for (genvar k = 0; k < AP_SLOTS; k++) begin : g_slot
        assign slot[k] = slots[k*AP_W +: AP_W];
    end

    always_comb begin
        case (kind)
            MAP_SECTION: idx = SLOT_IDX_W'(AP_SLOTS - 1);
            MAP_SMALL:   idx = small_sel;
            MAP_LARGE:   idx = large_sel;
            default:     idx = '0;
        endcase
    end

    assign ap         = slot[idx];
    assign is_section = (kind == MAP_SECTION);

    always_comb begin
        if (kind == MAP_SECTION)
            p_section_slot_r5: assert (ap == slots[AP_SLOTS*AP_W-1 -: AP_W])
                else $error("section did not take top slot");
        if (kind > MAP_LARGE)
            p_tiny_slot_r5: assert (ap == slots[AP_W-1:0])
                else $error("tiny/extended page did not take slot 0");
    end
endmodule

// File: rtl/perm_eval.sv
module perm_eval
    import dapc_pkg::*;
(
    input  logic [AP_W-1:0] ap,
    input  acc_ctx_t        ctx,
    output logic            allow
);
    assign allow = ap_allows(ap, ctx);

    always_comb begin
        if (ap == 2'd3)
            p_full_access_r6: assert (allow) else $error("AP 3 refused an access");
        if (ap == 2'd0 && ctx.is_write)
            p_ap0_write_r7: assert (!allow) else $error("AP 0 allowed a write");
        if (!ctx.is_priv && ctx.is_write && ap != 2'd3)
            p_user_write_r6: assert (!allow) else $error("user write allowed below AP 3");
    end
endmodule

// File: rtl/dom_perm_checker.sv
module dom_perm_checker
    import dapc_pkg::*;
(
    input  logic [2:0]                 map_kind,
    input  logic [DOM_W-1:0]           dom_id,
    input  logic [AP_SLOTS*AP_W-1:0]   ap_slots,
    input  logic [SLOT_IDX_W-1:0]      va_small_sel,
    input  logic [SLOT_IDX_W-1:0]      va_large_sel,
    input  logic                       is_write,
    input  logic                       is_priv,
    input  logic                       sys_s,
    input  logic                       sys_r,
    input  logic [2*NUM_DOMAINS-1:0]   dom_ctrl,
    output logic [1:0]                 fault_code,
    output logic [DOM_W-1:0]           fault_dom
);
    dom_mode_e       mode;
    logic [AP_W-1:0] ap_sel;
    logic            sect;
    logic            allow;
    acc_ctx_t        ctx;
    fault_e          flt;

    assign ctx = '{is_write: is_write, is_priv: is_priv, sys_s: sys_s, sys_r: sys_r};

    dom_mode_lookup #(.N_DOM(NUM_DOMAINS)) u_mode (
        .dom_ctrl (dom_ctrl),
        .dom_id   (dom_id),
        .mode     (mode)
    );

    ap_select u_ap (
        .kind       (map_kind),
        .slots      (ap_slots),
        .small_sel  (va_small_sel),
        .large_sel  (va_large_sel),
        .ap         (ap_sel),
        .is_section (sect)
    );

    perm_eval u_perm (
        .ap    (ap_sel),
        .ctx   (ctx),
        .allow (allow)
    );

    always_comb begin
        case (mode)
            DM_MANAGER: flt = FLT_NONE;
            DM_CLIENT: begin
                if (allow)     flt = FLT_NONE;
                else if (sect) flt = FLT_SECT_PERM;
                else           flt = FLT_PAGE_PERM;
            end
            default:    flt = FLT_SECT_DOM;
        endcase
    end

    assign fault_code = flt;
    assign fault_dom  = (flt == FLT_NONE) ? '0 : dom_id;

    always_comb begin
        if (mode == DM_MANAGER)
            p_manager_pass_r2: assert (fault_code == FLT_NONE)
                else $error("manager domain faulted");
        if (mode == DM_NOACC || mode == DM_RSVD)
            p_domain_fault_r3: assert (fault_code == FLT_SECT_DOM)
                else $error("no-access domain did not raise domain fault");
        if (mode == DM_CLIENT && !allow)
            p_perm_kind_r8: assert (fault_code == (sect ? FLT_SECT_PERM : FLT_PAGE_PERM))
                else $error("permission fault kind wrong");
        if (fault_code == FLT_NONE)
            p_dom_clear_r9: assert (fault_dom == '0)
                else $error("domain reported without fault");
    end
endmodule

// File: tb/tb_dom_perm_checker.sv
module tb_dom_perm_checker;
    logic        clk = 1'b0;
    logic [2:0]  map_kind;
    logic [3:0]  dom_id;
    logic [7:0]  ap_slots;
    logic [1:0]  va_small_sel, va_large_sel;
    logic        is_write, is_priv, sys_s, sys_r;
    logic [31:0] dom_ctrl;
    logic [1:0]  fault_code;
    logic [3:0]  fault_dom;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    dom_perm_checker dut (
        .map_kind(map_kind), .dom_id(dom_id), .ap_slots(ap_slots),
        .va_small_sel(va_small_sel), .va_large_sel(va_large_sel),
        .is_write(is_write), .is_priv(is_priv), .sys_s(sys_s), .sys_r(sys_r),
        .dom_ctrl(dom_ctrl), .fault_code(fault_code), .fault_dom(fault_dom)
    );

    function automatic logic [1:0] exp_ap();
        int k;
        case (map_kind)
            3'd0:    k = 3;
            3'd1:    k = va_small_sel;
            3'd2:    k = va_large_sel;
            default: k = 0;
        endcase
        return ap_slots[2*k +: 2];
    endfunction

    function automatic bit exp_ok(logic [1:0] ap);
        if (ap == 2'd3) return 1'b1;
        if (ap == 2'd2) return is_priv || !is_write;
        if (ap == 2'd1) return is_priv;
        if (is_write) return 1'b0;
        return sys_r || (is_priv && sys_s);
    endfunction

    function automatic logic [1:0] exp_code();
        logic [1:0] m;
        m = dom_ctrl[2*dom_id +: 2];
        if (m == 2'd3) return 2'd0;
        if (m != 2'd1) return 2'd3;
        if (exp_ok(exp_ap())) return 2'd0;
        return (map_kind == 3'd0) ? 2'd1 : 2'd2;
    endfunction

    task automatic check(string req, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(logic [2:0] k, logic [3:0] d, logic [7:0] s, logic [1:0] vs,
                         logic [1:0] vl, bit w, bit p, bit ss, bit rr, logic [31:0] dc);
        @(negedge clk);
        map_kind = k; dom_id = d; ap_slots = s; va_small_sel = vs; va_large_sel = vl;
        is_write = w; is_priv = p; sys_s = ss; sys_r = rr; dom_ctrl = dc;
        #2;
    endtask

    localparam logic [31:0] ALL_CLIENT = 32'h5555_5555;

    initial begin
        void'($urandom(32'h1A2B3C4D));
        // initial state: all-zero inputs, domain 0 has no access
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 32'h0);
        check("R3 idle code", fault_code, 2'd3);
        check("R9 idle domain", fault_dom, 4'd0);

        // R1: only domain 9 manager; domain 15 top field client
        drive(1, 9, 8'h00, 0, 0, 1, 0, 0, 0, 32'h000C_0000);
        check("R1 dom9 manager", fault_code, 2'd0);
        drive(1, 8, 8'h00, 0, 0, 1, 0, 0, 0, 32'h000C_0000);
        check("R1 dom8 no access", fault_code, 2'd3);
        drive(3, 15, 8'h03, 0, 0, 1, 0, 0, 0, 32'h4000_0000);
        check("R1 dom15 client pass", fault_code, 2'd0);
        drive(3, 15, 8'h00, 0, 0, 1, 0, 0, 0, 32'h4000_0000);
        check("R1 dom15 client fault", fault_code, 2'd2);
        check("R9 dom15 reported", fault_dom, 4'd15);
        drive(0, 4, 8'hFF, 0, 0, 0, 1, 1, 1, 32'h0000_0200);
        check("R3 reserved mode", fault_code, 2'd3);
        check("R9 dom4 reported", fault_dom, 4'd4);

        // R4: slot 3 open, others AP0; user write
        drive(1, 2, 8'hC0, 3, 0, 1, 0, 0, 0, ALL_CLIENT);
        check("R4 small slot3", fault_code, 2'd0);
        drive(1, 2, 8'hC0, 2, 3, 1, 0, 0, 0, ALL_CLIENT);
        check("R4 small slot2", fault_code, 2'd2);
        drive(2, 2, 8'hC0, 0, 3, 1, 0, 0, 0, ALL_CLIENT);
        check("R4 large slot3", fault_code, 2'd0);
        drive(2, 2, 8'hC0, 3, 1, 1, 0, 0, 0, ALL_CLIENT);
        check("R4 large slot1", fault_code, 2'd2);

        // R5: slot 3 open, slot 0 closed
        drive(0, 1, 8'hC0, 0, 0, 1, 0, 0, 0, ALL_CLIENT);
        check("R5 section top slot", fault_code, 2'd0);
        drive(3, 1, 8'hC0, 3, 3, 1, 0, 0, 0, ALL_CLIENT);
        check("R5 tiny slot0", fault_code, 2'd2);
        drive(4, 1, 8'hC0, 3, 3, 1, 0, 0, 0, ALL_CLIENT);
        check("R5 ext small slot0", fault_code, 2'd2);
        drive(6, 1, 8'hC0, 3, 3, 1, 0, 0, 0, ALL_CLIENT);
        check("R5 unused kind slot0", fault_code, 2'd2);
        drive(3, 1, 8'h03, 3, 3, 1, 0, 0, 0, ALL_CLIENT);
        check("R5 tiny open slot0", fault_code, 2'd0);

        // R6 via tiny page slot 0
        drive(3, 5, 8'h02, 0, 0, 1, 0, 0, 0, ALL_CLIENT);
        check("R6 AP2 user write", fault_code, 2'd2);
        drive(3, 5, 8'h02, 0, 0, 0, 0, 0, 0, ALL_CLIENT);
        check("R6 AP2 user read", fault_code, 2'd0);
        drive(3, 5, 8'h02, 0, 0, 1, 1, 0, 0, ALL_CLIENT);
        check("R6 AP2 priv write", fault_code, 2'd0);
        drive(3, 5, 8'h01, 0, 0, 0, 0, 1, 1, ALL_CLIENT);
        check("R6 AP1 user read", fault_code, 2'd2);
        drive(3, 5, 8'h01, 0, 0, 1, 1, 0, 0, ALL_CLIENT);
        check("R6 AP1 priv write", fault_code, 2'd0);
        drive(3, 5, 8'h03, 0, 0, 1, 0, 0, 0, ALL_CLIENT);
        check("R6 AP3 user write", fault_code, 2'd0);

        // R7: AP0
        drive(3, 6, 8'h00, 0, 0, 0, 1, 1, 0, ALL_CLIENT);
        check("R7 priv read S", fault_code, 2'd0);
        drive(3, 6, 8'h00, 0, 0, 0, 0, 1, 0, ALL_CLIENT);
        check("R7 user read S only", fault_code, 2'd2);
        drive(3, 6, 8'h00, 0, 0, 0, 0, 0, 1, ALL_CLIENT);
        check("R7 user read R", fault_code, 2'd0);
        drive(3, 6, 8'h00, 0, 0, 0, 1, 0, 0, ALL_CLIENT);
        check("R7 priv read no bits", fault_code, 2'd2);
        drive(3, 6, 8'h00, 0, 0, 1, 1, 1, 1, ALL_CLIENT);
        check("R7 write with S and R", fault_code, 2'd2);

        // R8 / R2
        drive(0, 7, 8'h3F, 0, 0, 1, 0, 0, 0, ALL_CLIENT);
        check("R8 section perm", fault_code, 2'd1);
        check("R9 dom7 reported", fault_dom, 4'd7);
        drive(0, 7, 8'h00, 0, 0, 1, 0, 0, 0, 32'hFFFF_FFFF);
        check("R2 manager ignores AP", fault_code, 2'd0);
        check("R9 no fault domain", fault_dom, 4'd0);

        // random
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] dc;
            logic [1:0]  ec;
            dc = (i % 3 == 0) ? $urandom() : ALL_CLIENT;
            drive(3'($urandom()), 4'($urandom()), 8'($urandom()), 2'($urandom()),
                  2'($urandom()), 1'($urandom()), 1'($urandom()), 1'($urandom()),
                  1'($urandom()), dc);
            ec = exp_code();
            check("R8 random code", fault_code, ec);
            check("R9 random domain", fault_dom, (ec == 2'd0) ? 4'd0 : dom_id);
        end
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule